// File: doc/BRIEF.md
# Double-Buffered Disk-to-Memory DMA Engine

This block takes bytes from a disk controller's data register and writes them into system memory. Each rising edge of the disk's data-request line asks for one byte. When counting and routing allow it, the engine pulses a read strobe, samples the byte and places it in one of two 16-byte staging buffers. When a buffer fills, the engine flips to the other buffer and raises a bus request. Once the bus is granted, it empties the full buffers into memory as 16-bit words, big-end first, starting at its DMA address.

Software loads a byte budget and a start address through load strobes. Two control inputs set the behaviour:
- `ctl_observe` routes disk requests to the engine.
- `ctl_to_disk` selects the transfer direction. Only the disk-to-memory direction moves data. Flipping this bit clears the engine's progress state.

Each grant ends in a one-cycle done pulse that carries the number of words written: 0, 8 or 16. The engine also has a sticky error flag. It rises when a buffer fills while the other buffer is still waiting to be drained.

Top module: `dskdma_top`

## Requirements
- R1: After reset, `bus_req`, `dma_err`, `mem_we`, `xfer_done` and `dreg_rd` are all low.
- R2: A rising edge of `dreq` produces exactly one `dreg_rd` pulse, and only when all four conditions hold: the byte budget is nonzero, `ctl_observe` is 1, `ctl_to_disk` is 0, and no drain is in progress. A request that arrives during a drain or a grant cycle is served after it. Each pulse lowers the budget by one.
- R3: Bytes are stored in arrival order in the active buffer. `bus_req` stays low through the first 15 bytes of a buffer and goes high once the 16th byte has been taken.
- R4: When a buffer fills and the other buffer is empty, filling moves to the other buffer with no error. When a buffer fills and the other buffer is still full, `dma_err` rises. It then stays high until `ctl_to_disk` changes.
- R5: `bus_req` is low in the cycle after `bus_gnt` is sampled high.
- R6: A grant drains the older, non-active buffer first, as 8 words on consecutive cycles. Word k is byte 2k in bits 15:8 and byte 2k+1 in bits 7:0. The address rises by 2 after each word. `xfer_words` is 8 when only this buffer was full.
- R7: If the active buffer is also full, it is drained next in the same way, and `xfer_words` is 16. Filling then restarts at byte 0 of the buffer, so the next 16 bytes raise `bus_req` again.
- R8: A grant that finds the older buffer empty gives a `xfer_done` pulse with `xfer_words` = 0 and no memory write.
- R9: The DMA address works as follows:
  - A word whose address is at or above `MEM_BYTES` is not written, but the address still advances.
  - The address wraps modulo 2^`ADDR_W`.
  - Bit 0 of a loaded address is forced to 0.
- R10: Any change of `ctl_to_disk` clears the byte budget, the fill position, the active buffer choice and `dma_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dreq | input | 1 | Disk data request, one rising edge per byte |
| dbyte | input | 8 | Disk data register contents |
| ctl_observe | input | 1 | Route disk requests to the engine |
| ctl_to_disk | input | 1 | Direction: 1 = memory-to-disk (moves nothing), 0 = disk-to-memory |
| cnt_load | input | 1 | Load the byte budget |
| cnt_value | input | CNT_W | Byte budget value |
| addr_load | input | 1 | Load the DMA address |
| addr_value | input | ADDR_W | DMA address value (bit 0 ignored) |
| dreg_rd | output | 1 | Read strobe for the data register; `dbyte` is sampled in this cycle |
| bus_req | output | 1 | Memory bus request |
| bus_gnt | input | 1 | Memory bus grant, one-cycle pulse |
| mem_we | output | 1 | Memory word write enable |
| mem_addr | output | ADDR_W | Memory byte address of the word |
| mem_wdata | output | 16 | Memory word data |
| xfer_done | output | 1 | One-cycle pulse at the end of a grant |
| xfer_words | output | $clog2(BUF_BYTES)+1 | Words written during that grant |
| dma_err | output | 1 | Sticky buffer overflow flag |

## Verification
The bench targets the boundary at the 15th and 16th byte of a buffer. A design that counts the fill position off by one raises the request one byte early or late, or shifts every stored byte by one.

It fills both buffers with no grant in between and then drains them. This checks three things:
- The error must rise, and it must not be cleared by the grant.
- The older bytes must reach memory first.
- After the double drain, filling must restart at byte 0. A design that leaves the fill position alone would never request again.

A load of address 501 near the top of a 512-byte space proves that bit 0 is dropped. The same run checks the address behaviour at the memory edge. Words above the 256-byte memory must be skipped. A design that writes them corrupts the model, and one that stalls the address puts later words in the wrong place after the wrap.

Budget exhaustion, a cleared observe bit and the memory-to-disk setting must each leave the read strobe silent.

// File: rtl/dskdma_pkg.sv
`timescale 1ns/1ps
// Shared types for the disk-to-memory DMA engine.
package dskdma_pkg;

    // Drain sequencer state
    typedef enum logic {
        DR_IDLE  = 1'b0,
        DR_BURST = 1'b1
    } drain_st_t;

    // One-hot select of one of the two staging buffers
    function automatic logic [1:0] buf_sel(input logic b);
        return b ? 2'b10 : 2'b01;
    endfunction

endpackage

// File: rtl/dskdma_stage.sv
`timescale 1ns/1ps
// Two staging buffers of BUF_BYTES bytes each.
// Write port: one byte per cycle. Read port: one 16-bit word, combinational.
// Byte 2k is returned in the high half of word k.
// Assumes BUF_BYTES is even and a power of two.
module dskdma_stage #(
    parameter int BUF_BYTES = 16
) (
    input  logic                                 clk,
    input  logic                                 wr_en,
    input  logic                                 wr_buf,
    input  logic [$clog2(BUF_BYTES)-1:0]         wr_idx,
    input  logic [7:0]                           wr_byte,
    input  logic                                 rd_buf,
    input  logic [$clog2(BUF_BYTES/2)-1:0]       rd_word,
    output logic [15:0]                          rd_data
);
    localparam int IW = $clog2(BUF_BYTES);

    logic [7:0] bytes_q [2][BUF_BYTES];
    logic [15:0] word_of [2];

    for (genvar b = 0; b < 2; b++) begin : g_buf
        // Store the incoming byte into this buffer when selected
        always_ff @(posedge clk) begin
            if (wr_en && (wr_buf == 1'(b)))
                bytes_q[b][wr_idx] <= wr_byte;
        end
        // Assemble the addressed word of this buffer
        always_comb begin
            word_of[b] = {bytes_q[b][{rd_word, 1'b0}], bytes_q[b][{rd_word, 1'b1}]};
        end
    end

    // Select the word from the requested buffer
    assign rd_data = word_of[rd_buf];

    logic unused_iw;
    assign unused_iw = ^IW;
endmodule

// File: rtl/dskdma_fill.sv
`timescale 1ns/1ps
// Fill side: serves disk data requests into the staging buffers.
// It also owns the byte budget, the fill position, the active buffer choice,
// the two full flags, the bus request and the sticky error flag.
// Assumes the drain side raises busy for the whole burst and clears a
// full flag only through clr_full.
module dskdma_fill
    import dskdma_pkg::*;
#(
    parameter int BUF_BYTES = 16,
    parameter int CNT_W     = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          drq,
    input  logic                          observe,
    input  logic                          to_disk,
    input  logic                          cnt_ld,
    input  logic [CNT_W-1:0]              cnt_val,
    input  logic                          gnt,
    input  logic                          busy,
    input  logic [1:0]                    clr_full,
    input  logic                          idx_rst,
    output logic                          rd_stb,
    output logic                          wr_en,
    output logic                          wr_buf,
    output logic [$clog2(BUF_BYTES)-1:0]  wr_idx,
    output logic                          act_buf,
    output logic [1:0]                    full,
    output logic                          breq,
    output logic                          err
);
    localparam int IW  = $clog2(BUF_BYTES);
    localparam int IW1 = IW + 1;
    localparam logic [IW1-1:0] FULL_AT = IW1'(BUF_BYTES);

    logic             drq_q, dir_q, pend_q;
    logic [CNT_W-1:0] cnt_q;
    logic [IW1-1:0]   idx_q, idx_next;
    logic             hold, dir_chg, take, store, at_full;
    logic [1:0]       full_q, full_next;

    assign hold    = busy | gnt;
    assign dir_chg = to_disk ^ dir_q;
    assign take    = pend_q & ~hold & observe & ~to_disk & (cnt_q != '0);
    assign store   = take & (idx_q < FULL_AT);
    assign idx_next = store ? idx_q + 1'b1 : idx_q;
    assign at_full = take & (idx_next == FULL_AT);

    assign rd_stb  = take;
    assign wr_en   = store;
    assign wr_buf  = act_buf;
    assign wr_idx  = idx_q[IW-1:0];
    assign full    = full_q;

    // Track request and direction history for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drq_q <= 1'b0;
            dir_q <= 1'b0;
        end else begin
            drq_q <= drq;
            dir_q <= to_disk;
        end
    end

    // Hold a request edge while the drain owns the buffers
    always_ff @(posedge clk) begin
        if (!rst_n)    pend_q <= 1'b0;
        else if (hold) pend_q <= pend_q | (drq & ~drq_q);
        else           pend_q <= drq & ~drq_q;
    end

    // Byte budget: load, decrement per byte taken, clear on direction change
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (dir_chg) cnt_q <= '0;
        else if (cnt_ld)  cnt_q <= cnt_val;
        else if (take)    cnt_q <= cnt_q - 1'b1;
    end

    // Next full flags: drain clears, a completed buffer sets
    always_comb begin
        full_next = full_q & ~clr_full;
        if (at_full) full_next = full_next | buf_sel(act_buf);
    end

    // Fill position, active buffer and error bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q   <= '0;
            act_buf <= 1'b0;
            err     <= 1'b0;
            full_q  <= 2'b00;
        end else begin
            full_q <= full_next;
            if (dir_chg) begin
                idx_q   <= '0;
                act_buf <= 1'b0;
                err     <= 1'b0;
            end else if (idx_rst) begin
                idx_q <= '0;
            end else if (at_full) begin
                if (full_q[~act_buf]) begin
                    err   <= 1'b1;
                    idx_q <= idx_next;
                end else begin
                    idx_q   <= '0;
                    act_buf <= ~act_buf;
                end
            end else if (take) begin
                idx_q <= idx_next;
            end
        end
    end

    // Bus request: set by a completed buffer, dropped by the grant
    always_ff @(posedge clk) begin
        if (!rst_n)       breq <= 1'b0;
        else if (gnt)     breq <= 1'b0;
        else if (at_full) breq <= 1'b1;
    end

    AST_BREQ_DROP: assert property (@(posedge clk) disable iff (!rst_n) gnt |=> !breq); // R5
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (err && (to_disk == dir_q)) |=> err); // R4
    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n) idx_q <= FULL_AT); // R3
endmodule

// File: rtl/dskdma_drain.sv
`timescale 1ns/1ps
// Drain side: on a bus grant, writes the full staging buffers to memory.
// It writes the older buffer first, then the active one if that is full too.
// Each buffer goes out as BUF_BYTES/2 words on consecutive cycles.
// Owns the DMA address. Words at or above MEM_BYTES are skipped, but the
// address still advances. Assumes grants arrive only while idle.
module dskdma_drain
    import dskdma_pkg::*;
#(
    parameter int          BUF_BYTES = 16,
    parameter int          ADDR_W    = 24,
    parameter int unsigned MEM_BYTES = 32'h0040_0000
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               gnt,
    input  logic                               act_buf,
    input  logic [1:0]                         full,
    input  logic                               addr_ld,
    input  logic [ADDR_W-1:0]                  addr_val,
    input  logic [15:0]                        rd_data,
    output logic                               rd_buf,
    output logic [$clog2(BUF_BYTES/2)-1:0]     rd_word,
    output logic                               busy,
    output logic [1:0]                         clr_full,
    output logic                               idx_rst,
    output logic                               mem_we,
    output logic [ADDR_W-1:0]                  mem_addr,
    output logic [15:0]                        mem_wdata,
    output logic                               done,
    output logic [$clog2(BUF_BYTES):0]         done_words
);
    localparam int WPB = BUF_BYTES / 2;
    localparam int WW  = $clog2(WPB);
    localparam int DW  = $clog2(BUF_BYTES) + 1;

    drain_st_t         st_q;
    logic              cur_q, second_q;
    logic [WW-1:0]     widx_q;
    logic [ADDR_W-1:0] addr_q;
    logic              last, in_range;

    assign busy      = (st_q == DR_BURST);
    assign last      = (widx_q == WW'(WPB - 1));
    assign in_range  = (32'(addr_q) < MEM_BYTES);
    assign rd_buf    = cur_q;
    assign rd_word   = widx_q;
    assign mem_we    = busy & in_range;
    assign mem_addr  = addr_q;
    assign mem_wdata = rd_data;
    assign clr_full  = (busy && last) ? buf_sel(cur_q) : 2'b00;
    assign idx_rst   = busy & last & second_q;

    // DMA address: load with bit 0 dropped, step by two per word slot
    always_ff @(posedge clk) begin
        if (!rst_n)       addr_q <= '0;
        else if (addr_ld) addr_q <= {addr_val[ADDR_W-1:1], 1'b0};
        else if (busy)    addr_q <= addr_q + ADDR_W'(2);
    end

    // Burst sequencer: pick the buffer, walk the words, report the total
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= DR_IDLE;
            cur_q      <= 1'b0;
            second_q   <= 1'b0;
            widx_q     <= '0;
            done       <= 1'b0;
            done_words <= '0;
        end else begin
            done <= 1'b0;
            case (st_q)
                DR_IDLE: begin
                    if (gnt) begin
                        if (full[~act_buf]) begin
                            st_q     <= DR_BURST;
                            cur_q    <= ~act_buf;
                            second_q <= 1'b0;
                            widx_q   <= '0;
                        end else begin
                            done       <= 1'b1;
                            done_words <= '0;
                        end
                    end
                end
                DR_BURST: begin
                    widx_q <= widx_q + 1'b1;
                    if (last) begin
                        if (!second_q && full[~cur_q]) begin
                            cur_q    <= ~cur_q;
                            second_q <= 1'b1;
                        end else begin
                            st_q       <= DR_IDLE;
                            done       <= 1'b1;
                            done_words <= second_q ? DW'(2 * WPB) : DW'(WPB);
                        end
                    end
                end
                default: st_q <= DR_IDLE;
            endcase
        end
    end

    AST_DONE_WORDS: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (done_words == '0 || done_words == DW'(WPB) || done_words == DW'(2 * WPB))); // R6
    AST_ADDR_EVEN: assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> !mem_addr[0]); // R9
    AST_GNT_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n) (gnt && busy) |=> busy); // R8
endmodule

// File: rtl/dskdma_top.sv
`timescale 1ns/1ps
// Double-buffered disk-to-memory DMA engine.
// Ties the fill side, the staging buffers and the drain side together.
// Assumes bus_gnt is a one-cycle pulse given in answer to bus_req, and that
// dbyte is valid from the rising edge of dreq until dreg_rd.
module dskdma_top #(
    parameter int          BUF_BYTES = 16,
    parameter int          CNT_W     = 16,
    parameter int          ADDR_W    = 24,
    parameter int unsigned MEM_BYTES = 32'h0040_0000
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           dreq,
    input  logic [7:0]                     dbyte,
    input  logic                           ctl_observe,
    input  logic                           ctl_to_disk,
    input  logic                           cnt_load,
    input  logic [CNT_W-1:0]               cnt_value,
    input  logic                           addr_load,
    input  logic [ADDR_W-1:0]              addr_value,
    output logic                           dreg_rd,
    output logic                           bus_req,
    input  logic                           bus_gnt,
    output logic                           mem_we,
    output logic [ADDR_W-1:0]              mem_addr,
    output logic [15:0]                    mem_wdata,
    output logic                           xfer_done,
    output logic [$clog2(BUF_BYTES):0]     xfer_words,
    output logic                           dma_err
);
    localparam int IW = $clog2(BUF_BYTES);
    localparam int WW = $clog2(BUF_BYTES / 2);

    logic          wr_en, wr_buf, act_buf, busy, idx_rst, rd_buf;
    logic [IW-1:0] wr_idx;
    logic [WW-1:0] rd_word;
    logic [1:0]    full, clr_full;
    logic [15:0]   rd_data;

    dskdma_fill #(.BUF_BYTES(BUF_BYTES), .CNT_W(CNT_W)) u_fill (
        .clk(clk), .rst_n(rst_n), .drq(dreq), .observe(ctl_observe),
        .to_disk(ctl_to_disk), .cnt_ld(cnt_load), .cnt_val(cnt_value),
        .gnt(bus_gnt), .busy(busy), .clr_full(clr_full), .idx_rst(idx_rst),
        .rd_stb(dreg_rd), .wr_en(wr_en), .wr_buf(wr_buf), .wr_idx(wr_idx),
        .act_buf(act_buf), .full(full), .breq(bus_req), .err(dma_err)
    );

    dskdma_stage #(.BUF_BYTES(BUF_BYTES)) u_stage (
        .clk(clk), .wr_en(wr_en), .wr_buf(wr_buf), .wr_idx(wr_idx),
        .wr_byte(dbyte), .rd_buf(rd_buf), .rd_word(rd_word), .rd_data(rd_data)
    );

    dskdma_drain #(.BUF_BYTES(BUF_BYTES), .ADDR_W(ADDR_W), .MEM_BYTES(MEM_BYTES)) u_drain (
        .clk(clk), .rst_n(rst_n), .gnt(bus_gnt), .act_buf(act_buf), .full(full),
        .addr_ld(addr_load), .addr_val(addr_value), .rd_data(rd_data),
        .rd_buf(rd_buf), .rd_word(rd_word), .busy(busy), .clr_full(clr_full),
        .idx_rst(idx_rst), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .done(xfer_done), .done_words(xfer_words)
    );

    AST_NO_STB_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> !dreg_rd); // R2
endmodule

// File: tb/sim_dskdma_top.sv
`timescale 1ns/1ps
module sim_dskdma_top;
    localparam int AW = 9;
    localparam int MB = 256;

    logic clk = 1'b0, rst_n = 1'b0;
    logic dreq = 0, ctl_observe = 0, ctl_to_disk = 0, cnt_load = 0, addr_load = 0, bus_gnt = 0;
    logic [7:0] dbyte = 0;
    logic [9:0] cnt_value = 0;
    logic [AW-1:0] addr_value = 0;
    logic dreg_rd, bus_req, mem_we, xfer_done, dma_err;
    logic [AW-1:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [4:0] xfer_words;

    int errors = 0, checks = 0;
    int stb_cnt = 0, wr_cnt = 0, beyond_cnt = 0, done_cnt = 0, last_words = -1;
    logic [15:0] mem [128];

    always #10 clk = ~clk;

    dskdma_top #(.BUF_BYTES(16), .CNT_W(10), .ADDR_W(AW), .MEM_BYTES(MB)) u0 (
        .clk(clk), .rst_n(rst_n), .dreq(dreq), .dbyte(dbyte),
        .ctl_observe(ctl_observe), .ctl_to_disk(ctl_to_disk),
        .cnt_load(cnt_load), .cnt_value(cnt_value),
        .addr_load(addr_load), .addr_value(addr_value),
        .dreg_rd(dreg_rd), .bus_req(bus_req), .bus_gnt(bus_gnt),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .xfer_done(xfer_done), .xfer_words(xfer_words), .dma_err(dma_err));

    // Observe the outputs away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (dreg_rd) stb_cnt++;
            if (mem_we) begin
                wr_cnt++;
                if (int'(mem_addr) >= MB) beyond_cnt++;
                else mem[mem_addr[7:1]] = mem_wdata;
            end
            if (xfer_done) begin
                done_cnt++;
                last_words = int'(xfer_words);
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send_byte(input int v);
        @(negedge clk); dbyte = 8'(v); dreq = 1'b1;
        @(negedge clk); dreq = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic grant_and_wait();
        int d0;
        d0 = done_cnt;
        @(negedge clk); bus_gnt = 1'b1;
        @(negedge clk); bus_gnt = 1'b0;
        chk(bus_req == 1'b0, "R5 bus_req after grant", int'(bus_req), 0);
        for (int i = 0; i < 40 && done_cnt == d0; i++) @(negedge clk);
    endtask

    task automatic load_cnt(input int n);
        @(negedge clk); cnt_value = 10'(n); cnt_load = 1'b1;
        @(negedge clk); cnt_load = 1'b0;
    endtask

    task automatic load_addr(input int a);
        @(negedge clk); addr_value = AW'(a); addr_load = 1'b1;
        @(negedge clk); addr_load = 1'b0;
    endtask

    task automatic flip_dir();
        @(negedge clk); ctl_to_disk = ~ctl_to_disk;
        @(negedge clk); ctl_to_disk = ~ctl_to_disk;
        @(negedge clk);
    endtask

    // Compare memory words k0..k1-1 of a burst from addr0 with byte stream v0
    task automatic check_words(input int addr0, input int v0, input int k0, input int k1, input string req);
        int bad, first_act, first_exp;
        bad = 0; first_act = 0; first_exp = 0;
        for (int k = k0; k < k1; k++) begin
            int a;
            logic [15:0] e;
            a = (addr0 + 2 * k) % 512;
            e = {8'(v0 + 2 * k), 8'(v0 + 2 * k + 1)};
            if (mem[a >> 1] !== e) begin
                if (bad == 0) begin first_act = int'(mem[a >> 1]); first_exp = int'(e); end
                bad++;
            end
        end
        chk(bad == 0, req, first_act, first_exp);
    endtask

    initial begin
        int s0, w0;
        repeat (3) @(negedge clk);
        chk(!bus_req && !dma_err && !mem_we && !xfer_done && !dreg_rd, "R1 reset outputs",
            int'({bus_req, dma_err, mem_we, xfer_done, dreg_rd}), 0);
        rst_n = 1'b1;
        ctl_observe = 1'b1;
        load_cnt(200);
        load_addr(16);

        // R3 / R6: a single buffer
        for (int i = 0; i < 15; i++) send_byte(i);
        chk(bus_req == 1'b0, "R3 no request after 15 bytes", int'(bus_req), 0);
        send_byte(15);
        chk(bus_req == 1'b1, "R3 request after 16 bytes", int'(bus_req), 1);
        chk(dma_err == 1'b0, "R4 swap without error", int'(dma_err), 0);
        w0 = wr_cnt;
        grant_and_wait();
        chk(last_words == 8, "R6 words per single drain", last_words, 8);
        chk(wr_cnt - w0 == 8, "R6 write count", wr_cnt - w0, 8);
        check_words(16, 0, 0, 8, "R6 memory contents single buffer");

        // R4 / R7: both buffers full before the grant
        for (int i = 16; i < 48; i++) send_byte(i);
        chk(dma_err == 1'b1, "R4 overflow error", int'(dma_err), 1);
        grant_and_wait();
        chk(last_words == 16, "R7 words per double drain", last_words, 16);
        check_words(32, 16, 0, 16, "R7 older buffer first then active");
        chk(dma_err == 1'b1, "R4 error sticky across grant", int'(dma_err), 1);

        // R8: grant with nothing staged
        w0 = wr_cnt;
        grant_and_wait();
        chk(last_words == 0, "R8 empty grant word count", last_words, 0);
        chk(wr_cnt == w0, "R8 empty grant writes", wr_cnt - w0, 0);

        // R10: direction change clears error and budget
        flip_dir();
        chk(dma_err == 1'b0, "R10 error cleared", int'(dma_err), 0);
        s0 = stb_cnt;
        send_byte(0);
        chk(stb_cnt == s0, "R10 budget cleared", stb_cnt - s0, 0);

        // R2: the budget limits the bytes taken
        load_cnt(3);
        s0 = stb_cnt;
        for (int i = 0; i < 5; i++) send_byte(i);
        chk(stb_cnt - s0 == 3, "R2 budget limit", stb_cnt - s0, 3);
        flip_dir();

        // R2: observe bit cleared
        ctl_observe = 1'b0;
        load_cnt(50);
        s0 = stb_cnt;
        send_byte(1); send_byte(2);
        chk(stb_cnt == s0, "R2 observe off", stb_cnt - s0, 0);
        ctl_observe = 1'b1;

        // R2: memory-to-disk direction moves nothing
        @(negedge clk); ctl_to_disk = 1'b1;
        load_cnt(50);
        s0 = stb_cnt;
        send_byte(3); send_byte(4);
        chk(stb_cnt == s0, "R2 memory-to-disk direction", stb_cnt - s0, 0);
        @(negedge clk); ctl_to_disk = 1'b0;
        @(negedge clk);

        // R9: odd load, memory edge, wrap
        load_cnt(100);
        load_addr(501);
        w0 = wr_cnt;
        for (int i = 0; i < 32; i++) send_byte(100 + i);
        grant_and_wait();
        chk(last_words == 16, "R9 words reported", last_words, 16);
        chk(wr_cnt - w0 == 10, "R9 writes above memory skipped", wr_cnt - w0, 10);
        chk(beyond_cnt == 0, "R9 no write above memory", beyond_cnt, 0);
        check_words(500, 100, 6, 16, "R9 address advance and wrap");

        // R7: fill restarts at byte 0 after a double drain
        for (int i = 0; i < 15; i++) send_byte(132 + i);
        chk(bus_req == 1'b0, "R7 no request after 15 new bytes", int'(bus_req), 0);
        send_byte(147);
        chk(bus_req == 1'b1, "R7 request after 16 new bytes", int'(bus_req), 1);
        grant_and_wait();
        chk(last_words == 8, "R6 words after restart", last_words, 8);
        check_words(20, 132, 0, 8, "R7 contents after restart");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule